// File: doc/BRIEF.md
# DES Round-Key Scheduler

This block turns a 64-bit DES key into the sixteen 48-bit round keys that a cipher core uses. It does not hold a table of all sixteen keys. It keeps only the two 28-bit key halves and rotates them once per round. The compression selection is then applied to the current halves, so the current round key is always present at the output.

A single load strobe captures the key and the direction. The parity bits are dropped and the remaining 56 bits are reordered. The first key of the chosen order is ready in the cycle after the load. Each step strobe from the cipher core moves to the next key. Encryption walks rounds 1 to 16 with left rotations. Decryption starts from the unrotated halves, which form the round-16 key, and walks back to round 1 with right rotations by the same amounts in reverse order. After the sixteenth key the round index stays at 16 and the key output reads zero.

Top module: `des_key_sched`

## Requirements
- R1: After reset, `key_valid_o` is 0, `round_o` is 16 and `rkey_o` is zero.
- R2: Bit 63 of `key_i` is DES key bit 1 and bit 0 is key bit 64. Bit 47 of `rkey_o` is round-key bit 1. The first key after an encrypt load is the standard round-1 key: PC-1 is applied, then both halves are rotated left by 1, then PC-2 is applied. For key 133457799BBCDFF1 the round-1 key is 1B02EFFC7072.
- R3: A load strobe sets `round_o` to 0 and `key_valid_o` to 1 in the next cycle.
- R4: In encrypt mode, after n steps (n from 0 to 15) `rkey_o` is the round n+1 key. Round r uses a cumulative left rotation of both halves equal to the sum of the per-round amounts 1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1 over rounds 1 to r. Each step adds one to `round_o`, and a rotation never changes the number of ones in the halves.
- R5: In decrypt mode, after n steps `rkey_o` is the round 16−n key. The first key uses the PC-1 halves with no rotation. The decrypt sequence is the encrypt sequence in reverse.
- R6: At round 16, `key_valid_o` is 0 and `rkey_o` is zero. Further steps leave `round_o` at 16.
- R7: A load in the same cycle as a step takes priority. A load in the middle of a sequence restarts it with the new key and direction.
- R8: The parity bits (the least significant bit of each byte of `key_i`) have no effect on any round key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture key and direction, restart at round index 0 |
| key_i | input | 64 | DES key, parity bits included |
| decrypt_i | input | 1 | Direction at load: 1 gives reverse (decryption) order |
| step_i | input | 1 | Advance to the next round key |
| rkey_o | output | 48 | Current round key, zero when not valid |
| round_o | output | 5 | Count of steps since load, 0 to 16 |
| key_valid_o | output | 1 | High while `round_o` is below 16 |

## Verification
The assertions check, on every cycle, how the round index behaves. A load clears it, a step advances it by one, and at 16 it stays put. They also check that every rotation keeps the number of ones in the halves and that a decrypt load stores the unrotated PC-1 halves. Only the bench scenarios can show the actual key values. These are the known round-1 and round-16 keys, the full encrypt and decrypt sequences against an independent model, the reversal between the two orders, parity-bit independence, and a restart in the middle of a sequence.

// File: rtl/des_ks_pkg.sv
package des_ks_pkg;
  localparam int KEY_W    = 64;
  localparam int CD_W     = 56;
  localparam int HALF_W   = CD_W / 2;
  localparam int RK_W     = 48;
  localparam int N_ROUNDS = 16;
  localparam int IDX_W    = $clog2(N_ROUNDS + 1);

  // Selection tables, 1-based, MSB-first bit numbering
  localparam byte unsigned SEL56 [0:CD_W-1] = '{
    57,49,41,33,25,17, 9, 1,58,50,42,34,26,18,
    10, 2,59,51,43,35,27,19,11, 3,60,52,44,36,
    63,55,47,39,31,23,15, 7,62,54,46,38,30,22,
    14, 6,61,53,45,37,29,21,13, 5,28,20,12, 4};

  localparam byte unsigned SEL48 [0:RK_W-1] = '{
    14,17,11,24, 1, 5, 3,28,15, 6,21,10,
    23,19,12, 4,26, 8,16, 7,27,20,13, 2,
    41,52,31,37,47,55,30,40,51,45,33,48,
    44,49,39,56,34,53,46,42,50,36,29,32};

  // Rotation amount of round r (0-based round number)
  function automatic int rot_amount(input int r);
    return (r == 0 || r == 1 || r == 8 || r == 15) ? 1 : 2;
  endfunction

  function automatic logic [CD_W-1:0] drop_parity(input logic [KEY_W-1:0] k);
    logic [CD_W-1:0] o;
    o = '0;
    for (int j = 0; j < CD_W; j++) o[CD_W-1-j] = k[KEY_W - int'(SEL56[j])];
    return o;
  endfunction

  function automatic logic [RK_W-1:0] compress(input logic [CD_W-1:0] cd);
    logic [RK_W-1:0] o;
    o = '0;
    for (int j = 0; j < RK_W; j++) o[RK_W-1-j] = cd[CD_W - int'(SEL48[j])];
    return o;
  endfunction

  function automatic logic [HALF_W-1:0] rotl(input logic [HALF_W-1:0] x, input int n);
    return (x << n) | (x >> (HALF_W - n));
  endfunction

  function automatic logic [HALF_W-1:0] rotr(input logic [HALF_W-1:0] x, input int n);
    return (x >> n) | (x << (HALF_W - n));
  endfunction
endpackage

// File: rtl/des_ks_pc1.sv
module des_ks_pc1
  import des_ks_pkg::*;
(
  input  logic [KEY_W-1:0] key_i,
  output logic [CD_W-1:0]  cd_o
);
  always_comb cd_o = drop_parity(key_i);
endmodule

// File: rtl/des_ks_pc2.sv
module des_ks_pc2
  import des_ks_pkg::*;
(
  input  logic [CD_W-1:0] cd_i,
  output logic [RK_W-1:0] rk_o
);
  always_comb rk_o = compress(cd_i);
endmodule

// File: rtl/des_ks_halves.sv
module des_ks_halves
  import des_ks_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             decrypt_i,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CD_W-1:0]  pc1_cd_i,
  output logic [CD_W-1:0]  cd_o
);
  logic [HALF_W-1:0] c_q, d_q, c_nx, d_nx;
  logic              dir_q;
  logic              dir_nx;
  int                amt;

  always_comb begin
    c_nx   = c_q;
    d_nx   = d_q;
    dir_nx = dir_q;
    amt    = 1;
    if (load_i) begin
      dir_nx = decrypt_i;
      if (decrypt_i) begin
        c_nx = pc1_cd_i[CD_W-1:HALF_W];
        d_nx = pc1_cd_i[HALF_W-1:0];
      end else begin
        c_nx = rotl(pc1_cd_i[CD_W-1:HALF_W], rot_amount(0));
        d_nx = rotl(pc1_cd_i[HALF_W-1:0], rot_amount(0));
      end
    end else if (adv_i) begin
      if (dir_q) begin
        amt  = rot_amount(N_ROUNDS - 1 - int'(idx_i));
        c_nx = rotr(c_q, amt);
        d_nx = rotr(d_q, amt);
      end else begin
        amt  = rot_amount(int'(idx_i) + 1);
        c_nx = rotl(c_q, amt);
        d_nx = rotl(d_q, amt);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q   <= '0;
      d_q   <= '0;
      dir_q <= 1'b0;
    end else begin
      c_q   <= c_nx;
      d_q   <= d_nx;
      dir_q <= dir_nx;
    end
  end

  assign cd_o = {c_q, d_q};

  a_r4_rotation_keeps_weight: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> ($countones(cd_o) == $past($countones(cd_o))));

  a_r5_decrypt_load_unrotated: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && decrypt_i) |=> (cd_o == $past(pc1_cd_i)));
endmodule

// File: rtl/des_key_sched.sv
module des_key_sched
  import des_ks_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             decrypt_i,
  input  logic             step_i,
  output logic [RK_W-1:0]  rkey_o,
  output logic [IDX_W-1:0] round_o,
  output logic             key_valid_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ROUNDS);

  logic [IDX_W-1:0] idx_q;
  logic [CD_W-1:0]  pc1_cd, cur_cd;
  logic [RK_W-1:0]  rk_raw;
  logic             adv;

  assign adv = step_i && !load_i && (idx_q < LAST_IDX - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          idx_q <= LAST_IDX;
    else if (load_i)                     idx_q <= '0;
    else if (step_i && idx_q < LAST_IDX) idx_q <= idx_q + 1'b1;
  end

  des_ks_pc1 u_pc1 (.key_i(key_i), .cd_o(pc1_cd));

  des_ks_halves u_halves (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .decrypt_i(decrypt_i),
    .adv_i(adv), .idx_i(idx_q), .pc1_cd_i(pc1_cd), .cd_o(cur_cd));

  des_ks_pc2 u_pc2 (.cd_i(cur_cd), .rk_o(rk_raw));

  assign key_valid_o = (idx_q < LAST_IDX);
  assign round_o     = idx_q;
  assign rkey_o      = key_valid_o ? rk_raw : '0;

  a_r3_load_clears_round: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (round_o == '0 && key_valid_o));

  a_r4_step_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && round_o < LAST_IDX) |=> (round_o == $past(round_o) + 1'b1));

  a_r6_saturate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && round_o == LAST_IDX) |=> (round_o == LAST_IDX && !key_valid_o));

  a_r6_round_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    round_o <= LAST_IDX);
endmodule

// File: tb/des_key_sched_bench.sv
module des_key_sched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [63:0] key_i = '0;
  logic        decrypt_i = 1'b0;
  logic        step_i = 1'b0;
  logic [47:0] rkey_o;
  logic [4:0]  round_o;
  logic        key_valid_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  des_key_sched u_des_key_sched (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .key_i(key_i),
    .decrypt_i(decrypt_i), .step_i(step_i), .rkey_o(rkey_o),
    .round_o(round_o), .key_valid_o(key_valid_o));

  // Independent reference: selection lists restated, cumulative rotation
  int T1 [56] = '{57,49,41,33,25,17,9,1,58,50,42,34,26,18,10,2,59,51,43,35,27,19,11,3,
                  60,52,44,36,63,55,47,39,31,23,15,7,62,54,46,38,30,22,14,6,61,53,45,37,
                  29,21,13,5,28,20,12,4};
  int T2 [48] = '{14,17,11,24,1,5,3,28,15,6,21,10,23,19,12,4,26,8,16,7,27,20,13,2,
                  41,52,31,37,47,55,30,40,51,45,33,48,44,49,39,56,34,53,46,42,50,36,29,32};

  function automatic logic [47:0] model(input logic [63:0] k, input bit dec, input int n);
    int r;
    int cum;
    logic [27:0] c, d, c2, d2;
    logic [55:0] cd;
    logic [47:0] o;
    r = dec ? 16 - n : n + 1;
    cum = 0;
    for (int j = 1; j <= r; j++) cum += (j == 1 || j == 2 || j == 9 || j == 16) ? 1 : 2;
    cum = cum % 28;
    for (int j = 0; j < 28; j++) begin
      c[27-j] = k[64 - T1[j]];
      d[27-j] = k[64 - T1[j+28]];
    end
    for (int i = 0; i < 28; i++) begin
      c2[27-i] = c[27 - ((i + cum) % 28)];
      d2[27-i] = d[27 - ((i + cum) % 28)];
    end
    cd = {c2, d2};
    for (int j = 0; j < 48; j++) o[47-j] = cd[56 - T2[j]];
    return o;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_load(input logic [63:0] k, input bit dec);
    key_i = k; decrypt_i = dec; load_i = 1'b1;
    tick();
    load_i = 1'b0;
  endtask

  // Walk a full sequence, check each key against the model, collect it
  task automatic run_seq(input logic [63:0] k, input bit dec, input string req,
                         output logic [47:0] got [16]);
    do_load(k, dec);
    step_i = 1'b1;
    for (int n = 0; n < 16; n++) begin
      got[n] = rkey_o;
      chk(round_o == 5'(n) && key_valid_o, req, {58'd0, key_valid_o, round_o}, {59'd1, 5'(n)});
      chk(rkey_o == model(k, dec, n), req, {16'd0, rkey_o}, {16'd0, model(k, dec, n)});
      tick();
    end
    step_i = 1'b0;
    chk(round_o == 5'd16 && !key_valid_o && rkey_o == '0, "R6",
        {10'd0, key_valid_o, round_o, rkey_o}, {11'd0, 5'd16, 48'd0});
  endtask

  task automatic t_reset();
    chk(!key_valid_o && round_o == 5'd16 && rkey_o == '0, "R1",
        {10'd0, key_valid_o, round_o, rkey_o}, {11'd0, 5'd16, 48'd0});
  endtask

  task automatic t_known();
    logic [47:0] g [16];
    run_seq(64'h133457799BBCDFF1, 1'b0, "R4", g);
    chk(g[0] == 48'h1B02EFFC7072, "R2", {16'd0, g[0]}, 64'h1B02EFFC7072);
    chk(g[15] == 48'hCB3D8B0E17F5, "R4", {16'd0, g[15]}, 64'hCB3D8B0E17F5);
    do_load(64'h133457799BBCDFF1, 1'b1);
    chk(rkey_o == 48'hCB3D8B0E17F5, "R5", {16'd0, rkey_o}, 64'hCB3D8B0E17F5);
    chk(round_o == 5'd0, "R3", {59'd0, round_o}, 64'd0);
  endtask

  task automatic t_reverse(input logic [63:0] k);
    logic [47:0] e [16];
    logic [47:0] dk [16];
    run_seq(k, 1'b0, "R4", e);
    run_seq(k, 1'b1, "R5", dk);
    for (int n = 0; n < 16; n++)
      chk(dk[n] == e[15-n], "R5", {16'd0, dk[n]}, {16'd0, e[15-n]});
  endtask

  task automatic t_fixed();
    logic [47:0] g [16];
    run_seq(64'h0, 1'b0, "R4", g);
    chk(g[7] == 48'h0, "R4", {16'd0, g[7]}, 64'h0);
    run_seq(64'hFEFEFEFEFEFEFEFE, 1'b1, "R5", g);
    chk(g[3] == 48'hFFFFFFFFFFFF, "R5", {16'd0, g[3]}, 64'hFFFFFFFFFFFF);
  endtask

  task automatic t_saturate();
    logic [47:0] g [16];
    run_seq(64'h0E329232EA6D0D73, 1'b0, "R4", g);
    step_i = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    step_i = 1'b0;
    chk(round_o == 5'd16 && !key_valid_o && rkey_o == '0, "R6",
        {10'd0, key_valid_o, round_o, rkey_o}, {11'd0, 5'd16, 48'd0});
  endtask

  task automatic t_restart();
    logic [63:0] k2;
    k2 = 64'hA1B2C3D4E5F60718;
    do_load(64'h0123456789ABCDEF, 1'b0);
    step_i = 1'b1;
    for (int i = 0; i < 5; i++) tick();
    chk(round_o == 5'd5, "R4", {59'd0, round_o}, 64'd5);
    key_i = k2; decrypt_i = 1'b1; load_i = 1'b1;
    tick();
    load_i = 1'b0; step_i = 1'b0;
    chk(round_o == 5'd0, "R7", {59'd0, round_o}, 64'd0);
    chk(rkey_o == model(k2, 1'b1, 0), "R7", {16'd0, rkey_o}, {16'd0, model(k2, 1'b1, 0)});
    step_i = 1'b1;
    tick();
    step_i = 1'b0;
    chk(rkey_o == model(k2, 1'b1, 1), "R7", {16'd0, rkey_o}, {16'd0, model(k2, 1'b1, 1)});
  endtask

  task automatic t_parity();
    logic [47:0] a [16];
    logic [47:0] b [16];
    run_seq(64'h5A5A5A5AC3C3C3C3, 1'b0, "R4", a);
    do_load(64'h5A5A5A5AC3C3C3C3 ^ 64'h0101010101010101, 1'b0);
    step_i = 1'b1;
    for (int n = 0; n < 16; n++) begin
      b[n] = rkey_o;
      tick();
    end
    step_i = 1'b0;
    for (int n = 0; n < 16; n++)
      chk(a[n] == b[n], "R8", {16'd0, b[n]}, {16'd0, a[n]});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #9;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_known();
    t_reverse(64'h0123456789ABCDEF);
    t_reverse(64'hF0E1D2C3B4A59687);
    t_fixed();
    t_saturate();
    t_restart();
    t_parity();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule